// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block is the interrupt back end of an endpoint that signals interrupts with MSI-X messages. It keeps one table entry for each of `NUM_VEC` vectors. Each entry holds a 64-bit message address, a 32-bit message payload and a control word whose low bit masks that vector. The table sits behind a 32-bit word-addressed slave port. A second, read-only port exposes the pending bits. A small capability control port carries the enable and function-wide mask bits. It also reports the table size.

The device raises per-vector trigger pulses, and it declares which vectors it actually uses through use and unuse pulses that move a per-vector counter. A trigger on a vector that is in use either goes out as an address/payload write on a valid/ready message port, or, if the vector is masked, is parked in its pending bit. A parked interrupt goes out later, when the vector becomes unmasked through its own mask bit or through the function-level state. When several messages are due together, they leave one at a time with the lowest vector first. Decoding base addresses, finding the capability in configuration space and splitting 8-byte bus accesses into two 32-bit ones all happen upstream. Writes aimed at the pending window are completed upstream with no effect, so the window has no write path.

Top module: `msix_ctrl`

## Requirements
- R1: After reset every table word reads 0 except each control word, which reads 1 (vector masked). The enable and mask-all bits read 0, every pending bit is 0, `msg_valid` is low, and `cap_table_size` reads `NUM_VEC-1`.
- R2: The table port is word addressed with four words per vector, at word address `4*v + k`. k=0 is the low address, k=1 the high address, k=2 the payload and k=3 the control word. Only control bit 0 (the mask) is stored, and bits 31:1 read 0. Word addresses of vectors at or above `NUM_VEC` read 0, and writes to them change nothing.
- R3: The function is masked while enable is 0 or mask-all is 1. A vector is masked while the function is masked or its own mask bit is 1.
- R4: A trigger on an in-use, unmasked vector produces one message with `msg_addr` = {high word, low word} and `msg_data` = payload of that vector.
- R5: A trigger on a vector whose use count is 0 is dropped: no message and no pending bit.
- R6: A trigger on an in-use, masked vector sets its pending bit and sends nothing.
- R7: The pending bit of vector v is bit (v mod 32) of pending word (v div 32). This is the same as bit (v mod 8) of byte (v div 8), little-endian. The window holds a multiple of 64 bits, and bits of vectors at or above `NUM_VEC` read 0.
- R8: When a vector with a pending bit becomes unmasked through its own control word, the pending bit clears and its message is sent.
- R9: When the function leaves the masked state (mask-all cleared or enable set), every pending vector that is now unmasked is replayed, lowest index first.
- R10: Each vector's use count increments on a use pulse and decrements on an unuse pulse, and it never goes below zero. When it reaches zero, the vector's pending bit clears.
- R11: The message port holds `msg_valid`, `msg_addr` and `msg_data` steady until `msg_ready`. Triggers that arrive during a stall are kept and sent later, lowest index first.
- R12: A control write with enable set produces a one-cycle `intx_clear` pulse on the next cycle. A control write with enable clear produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | TBL_WA | Table word address (4 words per vector) |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data for `tbl_addr` (combinational) |
| pnd_addr | input | PND_WA | Pending window word address |
| pnd_rdata | output | 32 | Pending window read data (combinational) |
| ctl_we | input | 1 | Capability control write strobe |
| ctl_enable_in | input | 1 | Enable value written on `ctl_we` |
| ctl_mask_all_in | input | 1 | Function mask-all value written on `ctl_we` |
| cap_enable | output | 1 | Current enable bit |
| cap_mask_all | output | 1 | Current function mask-all bit |
| cap_table_size | output | 11 | Table size field, `NUM_VEC-1` |
| intx_clear | output | 1 | Pulse asking the legacy interrupt line to drop |
| vec_trig | input | NUM_VEC | Per-vector trigger pulses |
| vec_use | input | NUM_VEC | Per-vector use pulses |
| vec_unuse | input | NUM_VEC | Per-vector unuse pulses |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
The bench builds the block with `NUM_VEC = 12` and `CNT_W = 4`. Twelve vectors is not a power of two, so some table word addresses decode to vectors that do not exist, and the upper bits of the padded 64-bit pending window must read zero. The pending bit of vector 11 lands in the second byte, which checks the byte/bit placement. A 4-bit use counter would wrap to 15 on an underflow, and a later single use would then leave it at zero and silently drop a trigger, so an unuse on an idle vector shows up at the message port.

// File: rtl/msix_pkg.sv
package msix_pkg;
   localparam int unsigned WORDS_PER_ENTRY = 4;
   localparam int unsigned PND_GRANULE     = 64;
   localparam int unsigned TSZ_W           = 11;

   typedef enum logic [1:0] {
      EW_ADDR_LO = 2'd0,
      EW_ADDR_HI = 2'd1,
      EW_DATA    = 2'd2,
      EW_CTRL    = 2'd3
   } entry_word_e;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned WA      = $clog2(NUM_VEC * WORDS_PER_ENTRY),
   parameter int unsigned IW      = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WA-1:0]      addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic [IW-1:0]      sel_idx,
   output logic [63:0]        sel_addr,
   output logic [31:0]        sel_data,
   output logic [NUM_VEC-1:0] mask_bits
);
   localparam int unsigned VW = WA - 2;

   logic [31:0]        lo_q  [NUM_VEC];
   logic [31:0]        hi_q  [NUM_VEC];
   logic [31:0]        dat_q [NUM_VEC];
   logic [NUM_VEC-1:0] msk_q;

   logic [VW-1:0] vidx;
   entry_word_e   wsel;

   assign vidx = addr[WA-1:2];
   assign wsel = entry_word_e'(addr[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            lo_q[v]  <= '0;
            hi_q[v]  <= '0;
            dat_q[v] <= '0;
         end
         msk_q <= '1;
      end else if (wr_en) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            if (vidx == VW'(v)) begin
               case (wsel)
                  EW_ADDR_LO: lo_q[v]  <= wdata;
                  EW_ADDR_HI: hi_q[v]  <= wdata;
                  EW_DATA:    dat_q[v] <= wdata;
                  default:    msk_q[v] <= wdata[0];
               endcase
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (vidx == VW'(v)) begin
            case (wsel)
               EW_ADDR_LO: rdata = lo_q[v];
               EW_ADDR_HI: rdata = hi_q[v];
               EW_DATA:    rdata = dat_q[v];
               default:    rdata = {31'd0, msk_q[v]};
            endcase
         end
      end
   end

   assign sel_addr  = {hi_q[sel_idx], lo_q[sel_idx]};
   assign sel_data  = dat_q[sel_idx];
   assign mask_bits = msk_q;
endmodule

// File: rtl/msix_vec_state.sv
module msix_vec_state #(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] trig,
   input  logic [NUM_VEC-1:0] use_req,
   input  logic [NUM_VEC-1:0] unuse_req,
   input  logic [NUM_VEC-1:0] masked,
   input  logic [NUM_VEC-1:0] grant,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] due
);
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic [CNT_W-1:0] cnt_q;
      logic             pend_q, due_q;
      logic             pend_nx, due_nx;
      logic             used, inc, dec, to_zero;

      assign used    = (cnt_q != '0);
      assign inc     = use_req[v] && !unuse_req[v] && (cnt_q != '1);
      assign dec     = unuse_req[v] && !use_req[v] && used;
      assign to_zero = dec && (cnt_q == CNT_W'(1));

      always_comb begin
         pend_nx = pend_q;
         due_nx  = due_q && !grant[v];
         if (trig[v] && used) begin
            if (masked[v]) pend_nx = 1'b1;
            else           due_nx  = 1'b1;
         end
         // a queued send that becomes masked falls back to pending
         if (masked[v] && due_nx) begin
            pend_nx = 1'b1;
            due_nx  = 1'b0;
         end
         // an unmasked vector with a parked interrupt replays it
         if (!masked[v] && pend_nx) begin
            pend_nx = 1'b0;
            due_nx  = 1'b1;
         end
         if (to_zero) pend_nx = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            due_q  <= 1'b0;
         end else begin
            pend_q <= pend_nx;
            due_q  <= due_nx;
            if (inc)      cnt_q <= cnt_q + CNT_W'(1);
            else if (dec) cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      assign pend[v] = pend_q;
      assign due[v]  = due_q;
   end
endmodule

// File: rtl/msix_send_arb.sv
module msix_send_arb #(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned IW      = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] due,
   output logic [NUM_VEC-1:0] grant,
   output logic [IW-1:0]      sel_idx,
   input  logic [63:0]        sel_addr,
   input  logic [31:0]        sel_data,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   logic          any, load;
   logic [IW-1:0] pick;
   logic          v_q;
   logic [63:0]   addr_q;
   logic [31:0]   data_q;

   always_comb begin
      pick = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (due[i]) pick = IW'(i);
      end
   end

   assign any  = |due;
   assign load = !v_q || msg_ready;

   always_comb begin
      grant = '0;
      if (load && any) grant[pick] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         v_q <= any;
         if (any) begin
            addr_q <= sel_addr;
            data_q <= sel_data;
         end
      end
   end

   assign sel_idx   = pick;
   assign msg_valid = v_q;
   assign msg_addr  = addr_q;
   assign msg_data  = data_q;
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned TBL_WA  = $clog2(NUM_VEC * WORDS_PER_ENTRY),
   parameter int unsigned PND_WA  = $clog2(((NUM_VEC + PND_GRANULE - 1) / PND_GRANULE) * 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_we,
   input  logic [TBL_WA-1:0]  tbl_addr,
   input  logic [31:0]        tbl_wdata,
   output logic [31:0]        tbl_rdata,
   input  logic [PND_WA-1:0]  pnd_addr,
   output logic [31:0]        pnd_rdata,
   input  logic               ctl_we,
   input  logic               ctl_enable_in,
   input  logic               ctl_mask_all_in,
   output logic               cap_enable,
   output logic               cap_mask_all,
   output logic [10:0]        cap_table_size,
   output logic               intx_clear,
   input  logic [NUM_VEC-1:0] vec_trig,
   input  logic [NUM_VEC-1:0] vec_use,
   input  logic [NUM_VEC-1:0] vec_unuse,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   localparam int unsigned IW        = $clog2(NUM_VEC);
   localparam int unsigned PND_BITS  = ((NUM_VEC + PND_GRANULE - 1) / PND_GRANULE) * PND_GRANULE;
   localparam int unsigned PND_WORDS = PND_BITS / 32;

   if (NUM_VEC < 2 || NUM_VEC > 2048) begin : g_bad_num_vec
      $error("NUM_VEC must lie in 2..2048");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("CNT_W must be at least 1");
   end
   if (TBL_WA != $clog2(NUM_VEC * WORDS_PER_ENTRY)) begin : g_bad_tbl_wa
      $error("TBL_WA does not match NUM_VEC");
   end
   if (PND_WA != $clog2(PND_WORDS)) begin : g_bad_pnd_wa
      $error("PND_WA does not match NUM_VEC");
   end

   logic               en_q, ma_q, intx_q;
   logic               func_masked;
   logic [NUM_VEC-1:0] mask_bits, vec_masked;
   logic [NUM_VEC-1:0] pend_vec, due_vec, grant_vec;
   logic [IW-1:0]      sel_idx;
   logic [63:0]        sel_addr;
   logic [31:0]        sel_data;
   logic [PND_BITS-1:0] pnd_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ma_q   <= 1'b0;
         intx_q <= 1'b0;
      end else begin
         intx_q <= ctl_we && ctl_enable_in;
         if (ctl_we) begin
            en_q <= ctl_enable_in;
            ma_q <= ctl_mask_all_in;
         end
      end
   end

   assign func_masked = !en_q || ma_q;
   assign vec_masked  = {NUM_VEC{func_masked}} | mask_bits;

   msix_vec_table #(.NUM_VEC(NUM_VEC), .WA(TBL_WA), .IW(IW)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_we),
      .addr      (tbl_addr),
      .wdata     (tbl_wdata),
      .rdata     (tbl_rdata),
      .sel_idx   (sel_idx),
      .sel_addr  (sel_addr),
      .sel_data  (sel_data),
      .mask_bits (mask_bits)
   );

   msix_vec_state #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (vec_trig),
      .use_req   (vec_use),
      .unuse_req (vec_unuse),
      .masked    (vec_masked),
      .grant     (grant_vec),
      .pend      (pend_vec),
      .due       (due_vec)
   );

   msix_send_arb #(.NUM_VEC(NUM_VEC), .IW(IW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .due       (due_vec),
      .grant     (grant_vec),
      .sel_idx   (sel_idx),
      .sel_addr  (sel_addr),
      .sel_data  (sel_data),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

   assign pnd_flat = PND_BITS'(pend_vec);

   always_comb begin
      pnd_rdata = '0;
      for (int w = 0; w < PND_WORDS; w++) begin
         if (pnd_addr == PND_WA'(w)) pnd_rdata = pnd_flat[w*32 +: 32];
      end
   end

   assign cap_enable     = en_q;
   assign cap_mask_all   = ma_q;
   assign cap_table_size = TSZ_W'(NUM_VEC - 1);
   assign intx_clear     = intx_q;
endmodule

// File: rtl/msix_ctrl_chk.sv
module msix_ctrl_chk #(
   parameter int unsigned NUM_VEC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [63:0]        msg_addr,
   input logic [31:0]        msg_data,
   input logic [NUM_VEC-1:0] pend,
   input logic [NUM_VEC-1:0] masked,
   input logic [NUM_VEC-1:0] grant
);
   // R11
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   // R11
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   replay_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & ~masked)) |=> ((pend & $past(pend & ~masked)) == '0));

   // R6
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(masked)) == '0);

   // R4
   msg_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(|grant));
endmodule

bind msix_ctrl msix_ctrl_chk #(.NUM_VEC(NUM_VEC)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_addr  (msg_addr),
   .msg_data  (msg_data),
   .pend      (pend_vec),
   .masked    (vec_masked),
   .grant     (grant_vec)
);

// File: tb/msix_ctrl_tb_top.sv
`timescale 1ns/1ps
module msix_ctrl_tb_top;
   localparam int NV  = 12;
   localparam int CW  = 4;
   localparam int TWA = $clog2(NV * 4);
   localparam int PWA = 1;

   logic           clk, rst_n;
   logic           tbl_we;
   logic [TWA-1:0] tbl_addr;
   logic [31:0]    tbl_wdata, tbl_rdata;
   logic [PWA-1:0] pnd_addr;
   logic [31:0]    pnd_rdata;
   logic           ctl_we, ctl_enable_in, ctl_mask_all_in;
   logic           cap_enable, cap_mask_all, intx_clear;
   logic [10:0]    cap_table_size;
   logic [NV-1:0]  vec_trig, vec_use, vec_unuse;
   logic           msg_valid, msg_ready;
   logic [63:0]    msg_addr;
   logic [31:0]    msg_data;

   msix_ctrl #(.NUM_VEC(NV), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
      .pnd_addr(pnd_addr), .pnd_rdata(pnd_rdata),
      .ctl_we(ctl_we), .ctl_enable_in(ctl_enable_in), .ctl_mask_all_in(ctl_mask_all_in),
      .cap_enable(cap_enable), .cap_mask_all(cap_mask_all), .cap_table_size(cap_table_size),
      .intx_clear(intx_clear),
      .vec_trig(vec_trig), .vec_use(vec_use), .vec_unuse(vec_unuse),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // stimulus/expected table for the table port: word address, write data, read-back
   localparam logic [5:0]  TV_A [8] = '{6'd0, 6'd1, 6'd2, 6'd4, 6'd6, 6'd27, 6'd52, 6'd3};
   localparam logic [31:0] TV_D [8] = '{32'hFEE0_0000, 32'h0000_0001, 32'h0000_0040,
                                        32'hFEE0_1000, 32'h0000_0041, 32'hFFFF_FFFF,
                                        32'hDEAD_BEEF, 32'hFFFF_FFFE};
   localparam logic [31:0] TV_E [8] = '{32'hFEE0_0000, 32'h0000_0001, 32'h0000_0040,
                                        32'hFEE0_1000, 32'h0000_0041, 32'h0000_0001,
                                        32'h0000_0000, 32'h0000_0000};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lo_of(input int v);
      return 32'hFEE0_0000 | (32'(v) << 4);
   endfunction
   function automatic logic [31:0] dat_of(input int v);
      return 32'h0000_0100 + 32'(v);
   endfunction

   task automatic tbl_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = TWA'(a); tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic tbl_rd(input int a, output logic [31:0] d);
      tbl_addr = TWA'(a);
      #1;
      d = tbl_rdata;
   endtask

   task automatic pnd_rd(input int w, output logic [31:0] d);
      pnd_addr = PWA'(w);
      #1;
      d = pnd_rdata;
   endtask

   task automatic ctl_wr(input logic en, input logic ma, output logic ic);
      @(negedge clk);
      ctl_we = 1'b1; ctl_enable_in = en; ctl_mask_all_in = ma;
      @(negedge clk);
      ic = intx_clear;
      ctl_we = 1'b0;
   endtask

   task automatic pulse_trig(input logic [NV-1:0] m);
      @(negedge clk); vec_trig = m;
      @(negedge clk); vec_trig = '0;
   endtask
   task automatic pulse_use(input logic [NV-1:0] m);
      @(negedge clk); vec_use = m;
      @(negedge clk); vec_use = '0;
   endtask
   task automatic pulse_unuse(input logic [NV-1:0] m);
      @(negedge clk); vec_unuse = m;
      @(negedge clk); vec_unuse = '0;
   endtask

   task automatic set_vec(input int v);
      tbl_wr(v*4 + 0, lo_of(v));
      tbl_wr(v*4 + 1, 32'd0);
      tbl_wr(v*4 + 2, dat_of(v));
   endtask

   task automatic wait_msg(input int v, input string tag);
      bit found = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (msg_valid) begin
            chk({tag, " addr"}, msg_addr, {32'd0, lo_of(v)});
            chk({tag, " data"}, {32'd0, msg_data}, {32'd0, dat_of(v)});
            found = 1'b1;
            break;
         end
      end
      if (!found) chk({tag, " message seen"}, 64'd0, 64'd1);
   endtask

   task automatic no_msg(input int n, input string tag);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (msg_valid) seen = 1'b1;
      end
      chk(tag, {63'd0, seen}, 64'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all R) actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        ic;
      logic [63:0] held_addr;
      rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; pnd_addr = '0;
      ctl_we = 1'b0; ctl_enable_in = 1'b0; ctl_mask_all_in = 1'b0;
      vec_trig = '0; vec_use = '0; vec_unuse = '0; msg_ready = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 enable", {63'd0, cap_enable}, 64'd0);
      chk("R1 mask_all", {63'd0, cap_mask_all}, 64'd0);
      chk("R1 table size", {53'd0, cap_table_size}, 64'd11);
      tbl_rd(3, rd);  chk("R1 v0 ctrl", {32'd0, rd}, 64'd1);
      tbl_rd(43, rd); chk("R1 v10 ctrl", {32'd0, rd}, 64'd1);
      tbl_rd(20, rd); chk("R1 v5 lo", {32'd0, rd}, 64'd0);
      pnd_rd(0, rd);  chk("R1 pending w0", {32'd0, rd}, 64'd0);
      chk("R1 msg_valid", {63'd0, msg_valid}, 64'd0);

      // R2 table layout walk
      for (int i = 0; i < 8; i++) begin
         tbl_wr(int'(TV_A[i]), TV_D[i]);
         @(negedge clk);
         tbl_rd(int'(TV_A[i]), rd);
         chk($sformatf("R2 table vector %0d", i), {32'd0, rd}, {32'd0, TV_E[i]});
      end

      // program vectors, declare use, unmask 1,2,4,5
      for (int v = 1; v < NV; v++) set_vec(v);
      tbl_wr(1*4 + 3, 32'd0);
      tbl_wr(2*4 + 3, 32'd0);
      tbl_wr(4*4 + 3, 32'd0);
      tbl_wr(5*4 + 3, 32'd0);
      pulse_use(12'b0000_0001_1110);
      ctl_wr(1'b1, 1'b0, ic);
      chk("R12 intx_clear on enable", {63'd0, ic}, 64'd1);
      chk("R3 enable readback", {63'd0, cap_enable}, 64'd1);

      // R4 basic send
      pulse_trig(12'b0000_0000_0100);
      wait_msg(2, "R4 vec2");

      // R5 unused vector dropped
      pulse_trig(12'b0000_0010_0000);
      no_msg(6, "R5 no message for unused vector");
      pnd_rd(0, rd); chk("R5 no pending", {32'd0, rd}, 64'd0);

      // R6 masked vector parks
      pulse_trig(12'b0000_0000_1000);
      pnd_rd(0, rd); chk("R6 pending bit3", {32'd0, rd}, 64'h8);
      no_msg(4, "R6 no message while masked");

      // R8 per-vector unmask replays
      tbl_wr(3*4 + 3, 32'd0);
      wait_msg(3, "R8 replay vec3");
      @(negedge clk);
      pnd_rd(0, rd); chk("R8 pending cleared", {32'd0, rd}, 64'd0);

      // R3/R9 function mask then replay lowest first
      ctl_wr(1'b1, 1'b1, ic);
      pulse_trig(12'b0000_0001_0110);
      pnd_rd(0, rd); chk("R3 function mask parks", {32'd0, rd}, 64'h16);
      no_msg(4, "R3 no message while function masked");
      ctl_wr(1'b1, 1'b0, ic);
      wait_msg(1, "R9 replay first");
      wait_msg(2, "R9 replay second");
      wait_msg(4, "R9 replay third");

      // R11 stall holds, retrigger kept, lowest first
      @(negedge clk); msg_ready = 1'b0;
      pulse_trig(12'b0000_0000_0110);
      @(negedge clk);
      chk("R11 valid under stall", {63'd0, msg_valid}, 64'd1);
      chk("R11 lowest first", msg_addr, {32'd0, lo_of(1)});
      held_addr = msg_addr;
      repeat (2) @(negedge clk);
      chk("R11 addr held", msg_addr, held_addr);
      pulse_trig(12'b0000_0000_0010);
      chk("R11 still held after retrigger", msg_addr, held_addr);
      msg_ready = 1'b1;
      wait_msg(1, "R11 retrigger kept");
      wait_msg(2, "R11 later vector");

      // R12 and R9: disable, park, re-enable
      ctl_wr(1'b0, 1'b0, ic);
      chk("R12 no intx_clear on disable", {63'd0, ic}, 64'd0);
      pulse_trig(12'b0000_0000_0100);
      pnd_rd(0, rd); chk("R3 disabled parks vec2", {32'd0, rd}, 64'h4);
      ctl_wr(1'b1, 1'b0, ic);
      chk("R12 intx_clear on re-enable", {63'd0, ic}, 64'd1);
      wait_msg(2, "R9 replay after enable");

      // R10 use counter
      pulse_use(12'b0010_0000_0000);
      pulse_trig(12'b0010_0000_0000);
      pnd_rd(0, rd); chk("R10 pending vec9", {32'd0, rd}, 64'h200);
      pulse_unuse(12'b0010_0000_0000);
      pnd_rd(0, rd); chk("R10 zero count clears pending", {32'd0, rd}, 64'd0);
      pulse_unuse(12'b0010_0000_0000);
      pulse_use(12'b0010_0000_0000);
      tbl_wr(9*4 + 3, 32'd0);
      pulse_trig(12'b0010_0000_0000);
      wait_msg(9, "R10 no underflow");

      // R7 pending placement and padding
      pulse_use(12'b1000_0000_0000);
      pulse_trig(12'b1000_0000_0000);
      pnd_rd(0, rd); chk("R7 vec11 bit", {32'd0, rd}, 64'h800);
      pnd_rd(1, rd); chk("R7 padding word", {32'd0, rd}, 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule